// File: doc/BRIEF.md
# Wake-up Line Controller Register Bank

This block is the register file that sits between an APB bus and the trigger and masking logic of a multi-line wake-up, interrupt and event controller. For every line it keeps a rising-edge enable, a falling-edge enable, an interrupt mask and an event mask. Configurable lines also get a software trigger bit and a pending bit. The block drives all of these to the trigger logic as flat per-line vectors. The trigger logic in turn returns one pending-set strobe per configurable line.

Software configures edge sensitivity and masks with word writes. It fires a line by writing 1 to its software trigger bit. It acknowledges an interrupt by writing 1 to the line's pending bit. A pending bit is also dropped when the edge sensitivity of its line is reprogrammed, so a stale request from the old configuration cannot survive. Two configurable banks and three mask words are built by default. Every implemented-bit mask and every reset word is a parameter.

Top module: `wkc_regbank`

## Requirements
- R1: After reset, all edge-enable, software-trigger, event-mask and pending bits are 0. Interrupt-mask word 0 (offset 0x80) reads 0xFFC0_0000: the direct lines in bits 31:22 come up unmasked and the configurable lines in bits 21:0 come up masked. Word 1 (0x90) reads 0x0FB5_BFFB and word 2 (0xA0) reads 0x0000_2000.
- R2: A write is carried out only when it is word-aligned (paddr[1:0] = 0) and pstrb = 4'hF. Any other write, and any misaligned read, raises pslverr in its access phase and changes no register. pready is always 1.
- R3: Writing 1 to a software-trigger bit drives that line of sw_trig high for exactly the one cycle after the access phase. Writing 0 has no effect. The trigger registers always read 0.
- R4: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R5: A pending-set strobe on an implemented configurable line sets that line's pending bit. The bit stays set until it is cleared. Strobes on unimplemented bits are ignored.
- R6: A write to a rising-enable or falling-enable register clears the pending bit of every line whose enable value actually changes. Lines written with their current value keep their pending bit.
- R7: Reserved bits read as 0 and ignore writes. Configurable bank 0 implements bits 21:0. Bank 1 implements bits 2, 14, 17, 19 and 22. Mask word 0 implements bits 31:0, word 1 implements bits 27:0, and word 2 implements bit 13 only. The event mask at each word uses the same bits as the interrupt mask at that word.
- R8: When a pending-set strobe and a clear of the same bit (write-one-to-clear or sensitivity change) fall in the same cycle, the bit ends up set.
- R9: The address map is as follows. Bank b has rising enable at 0x20·b, falling enable at 0x20·b+4 and software trigger at 0x20·b+8. Mask word w has interrupt mask at 0x80+0x10·w and event mask at 0x84+0x10·w. Pending for bank b is at 0x88+0x10·b. Unmapped offsets read 0 and ignore writes.
- R10: While psel is high, prdata shows the register selected by paddr, with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; only 4'hF writes are serviced |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error for refused accesses |
| pend_set | input | 64 | Pending-set strobes, 32 per configurable bank |
| rise_en | output | 64 | Rising-edge enables, 32 per bank |
| fall_en | output | 64 | Falling-edge enables, 32 per bank |
| sw_trig | output | 64 | One-cycle software trigger pulses |
| pending | output | 64 | Pending bits |
| int_mask | output | 96 | Interrupt masks, 32 per mask word |
| evt_mask | output | 96 | Event masks, 32 per mask word |

## Verification
The pending bit has a hardware setter and two software clearers, and they can land in the same cycle. This happens when a pend_set strobe arrives during the access phase of a write-one-to-clear, or during an edge-enable write that flips the same line. The bench forces both collisions on purpose. It also makes them happen at random by driving pend_set alongside random bus writes. A per-cycle behavioural model, in which the set is applied after all clears, judges every cycle's pending vector and read data.

// File: rtl/wkc_regs_pkg.sv
package wkc_regs_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned CFG_STRIDE  = 32'h20;
    localparam int unsigned OFF_RISE    = 32'h0;
    localparam int unsigned OFF_FALL    = 32'h4;
    localparam int unsigned OFF_TRIG    = 32'h8;
    localparam int unsigned MASK_BASE   = 32'h80;
    localparam int unsigned MASK_STRIDE = 32'h10;
    localparam int unsigned OFF_IMASK   = 32'h0;
    localparam int unsigned OFF_EMASK   = 32'h4;
    localparam int unsigned OFF_PEND    = 32'h8;

    typedef enum logic [2:0] {
        K_NONE,
        K_RISE,
        K_FALL,
        K_TRIG,
        K_PEND,
        K_IMASK,
        K_EMASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

endpackage

// File: rtl/wkc_apb_decode.sv
module wkc_apb_decode
    import wkc_regs_pkg::*;
#(
    parameter int AW         = 8,
    parameter int CFG_BANKS  = 2,
    parameter int MASK_WORDS = 3
) (
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [3:0]    pstrb,
    output reg_sel_t      sel,
    output logic          wr_ok,
    output logic          slverr
);

    logic        access;
    int unsigned addr_i;

    always_comb begin
        access = psel && penable;
        addr_i = 32'(paddr);
        sel    = '{kind: K_NONE, idx: 4'd0};
        for (int unsigned b = 0; b < CFG_BANKS; b++) begin
            if (addr_i == b * CFG_STRIDE + OFF_RISE) sel = '{kind: K_RISE, idx: 4'(b)};
            if (addr_i == b * CFG_STRIDE + OFF_FALL) sel = '{kind: K_FALL, idx: 4'(b)};
            if (addr_i == b * CFG_STRIDE + OFF_TRIG) sel = '{kind: K_TRIG, idx: 4'(b)};
        end
        for (int unsigned w = 0; w < MASK_WORDS; w++) begin
            if (addr_i == MASK_BASE + w * MASK_STRIDE + OFF_IMASK) sel = '{kind: K_IMASK, idx: 4'(w)};
            if (addr_i == MASK_BASE + w * MASK_STRIDE + OFF_EMASK) sel = '{kind: K_EMASK, idx: 4'(w)};
            if (w < CFG_BANKS && addr_i == MASK_BASE + w * MASK_STRIDE + OFF_PEND)
                sel = '{kind: K_PEND, idx: 4'(w)};
        end
        slverr = access && ((paddr[1:0] != 2'b00) || (pwrite && pstrb != 4'hF));
        wr_ok  = access && pwrite && !slverr;
    end

endmodule

// File: rtl/wkc_cfg_bank.sv
module wkc_cfg_bank #(
    parameter logic [31:0] IMPL = 32'h003F_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_rise,
    input  logic        wr_fall,
    input  logic        wr_trig,
    input  logic        wr_pend,
    input  logic [31:0] wdata,
    input  logic [31:0] set_strb,
    output logic [31:0] rise,
    output logic [31:0] fall,
    output logic [31:0] trig,
    output logic [31:0] pend
);

    typedef struct packed {
        logic [31:0] rise;
        logic [31:0] fall;
        logic [31:0] trig;
        logic [31:0] pend;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [31:0] wdata_m;
    logic [31:0] sens_chg;
    logic [31:0] w1c;

    always_comb begin
        wdata_m  = wdata & IMPL;
        st_d     = st_q;
        st_d.trig = '0;
        sens_chg = '0;
        w1c      = '0;
        if (wr_rise) begin
            sens_chg  = st_q.rise ^ wdata_m;
            st_d.rise = wdata_m;
        end
        if (wr_fall) begin
            sens_chg  = st_q.fall ^ wdata_m;
            st_d.fall = wdata_m;
        end
        if (wr_trig) st_d.trig = wdata_m;
        if (wr_pend) w1c = wdata_m;
        // set is applied after both clears so a colliding strobe wins
        st_d.pend = ((st_q.pend & ~(w1c | sens_chg)) | set_strb) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.rise;
    assign fall = st_q.fall;
    assign trig = st_q.trig;
    assign pend = st_q.pend;

    // R3: a trigger pulse only follows a trigger write, and lasts one cycle
    p_trig_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig != '0) |-> $past(wr_trig));
    p_trig_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_trig |=> (trig == '0));

    // R4: a write-one-to-clear without a colliding strobe empties those bits
    p_pend_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && set_strb == '0) |=> ((pend & $past(wdata & IMPL)) == '0));

    // R5: no pending bit rises without a strobe on it
    p_pend_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend & ~$past(pend)) & ~$past(set_strb)) == '0));

    // R6: changed rising sensitivity drops the pending bit
    p_sens_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && set_strb == '0) |=> ((pend & $past((rise ^ wdata) & IMPL)) == '0));

    // R8: a strobe always leaves its bit set, whatever clear collides
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_strb != '0) |=> ((pend & $past(set_strb & IMPL)) == $past(set_strb & IMPL)));

endmodule

// File: rtl/wkc_mask_word.sv
module wkc_mask_word #(
    parameter logic [31:0] IMPL   = 32'hFFFF_FFFF,
    parameter logic [31:0] IM_RST = 32'hFFC0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_im,
    input  logic        wr_em,
    input  logic [31:0] wdata,
    output logic [31:0] im,
    output logic [31:0] em
);

    localparam logic [31:0] IM_RST_M = IM_RST & IMPL;

    typedef struct packed {
        logic [31:0] im;
        logic [31:0] em;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_im) st_d.im = wdata & IMPL;
        if (wr_em) st_d.em = wdata & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.im <= IM_RST_M;
            st_q.em <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign im = st_q.im;
    assign em = st_q.em;

    // R9: a mask word moves only on a write to its own offset
    p_imask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_im |=> $stable(im));
    p_emask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_em |=> $stable(em));

endmodule

// File: rtl/wkc_regbank.sv
module wkc_regbank
    import wkc_regs_pkg::*;
#(
    parameter int AW         = 8,
    parameter int CFG_BANKS  = 2,
    parameter int MASK_WORDS = 3,
    parameter logic [CFG_BANKS-1:0][31:0]  CFG_IMPL  = {32'h004A_4004, 32'h003F_FFFF},
    parameter logic [MASK_WORDS-1:0][31:0] MASK_IMPL = {32'h0000_2000, 32'h0FFF_FFFF, 32'hFFFF_FFFF},
    parameter logic [MASK_WORDS-1:0][31:0] IMASK_RST = {32'h0000_2000, 32'h0FB5_BFFB, 32'hFFC0_0000},
    localparam int CFG_LINES  = CFG_BANKS * WORD_W,
    localparam int MASK_LINES = MASK_WORDS * WORD_W
) (
    input  logic                  pclk,
    input  logic                  presetn,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [AW-1:0]         paddr,
    input  logic [31:0]           pwdata,
    input  logic [3:0]            pstrb,
    output logic [31:0]           prdata,
    output logic                  pready,
    output logic                  pslverr,
    input  logic [CFG_LINES-1:0]  pend_set,
    output logic [CFG_LINES-1:0]  rise_en,
    output logic [CFG_LINES-1:0]  fall_en,
    output logic [CFG_LINES-1:0]  sw_trig,
    output logic [CFG_LINES-1:0]  pending,
    output logic [MASK_LINES-1:0] int_mask,
    output logic [MASK_LINES-1:0] evt_mask
);

    reg_sel_t    sel;
    logic        wr_ok;
    logic [31:0] rise_w [CFG_BANKS];
    logic [31:0] fall_w [CFG_BANKS];
    logic [31:0] pend_w [CFG_BANKS];
    logic [31:0] im_w   [MASK_WORDS];
    logic [31:0] em_w   [MASK_WORDS];

    wkc_apb_decode #(
        .AW         (AW),
        .CFG_BANKS  (CFG_BANKS),
        .MASK_WORDS (MASK_WORDS)
    ) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pstrb   (pstrb),
        .sel     (sel),
        .wr_ok   (wr_ok),
        .slverr  (pslverr)
    );

    assign pready = 1'b1;

    for (genvar b = 0; b < CFG_BANKS; b++) begin : g_cfg
        logic hit;
        assign hit = wr_ok && (sel.idx == 4'(b));
        wkc_cfg_bank #(
            .IMPL (CFG_IMPL[b])
        ) u_bank (
            .clk      (pclk),
            .rst_n    (presetn),
            .wr_rise  (hit && sel.kind == K_RISE),
            .wr_fall  (hit && sel.kind == K_FALL),
            .wr_trig  (hit && sel.kind == K_TRIG),
            .wr_pend  (hit && sel.kind == K_PEND),
            .wdata    (pwdata),
            .set_strb (pend_set[b*WORD_W +: WORD_W]),
            .rise     (rise_w[b]),
            .fall     (fall_w[b]),
            .trig     (sw_trig[b*WORD_W +: WORD_W]),
            .pend     (pend_w[b])
        );
        assign rise_en[b*WORD_W +: WORD_W] = rise_w[b];
        assign fall_en[b*WORD_W +: WORD_W] = fall_w[b];
        assign pending[b*WORD_W +: WORD_W] = pend_w[b];
    end

    for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask
        logic hit;
        assign hit = wr_ok && (sel.idx == 4'(w));
        wkc_mask_word #(
            .IMPL   (MASK_IMPL[w]),
            .IM_RST (IMASK_RST[w])
        ) u_word (
            .clk   (pclk),
            .rst_n (presetn),
            .wr_im (hit && sel.kind == K_IMASK),
            .wr_em (hit && sel.kind == K_EMASK),
            .wdata (pwdata),
            .im    (im_w[w]),
            .em    (em_w[w])
        );
        assign int_mask[w*WORD_W +: WORD_W] = im_w[w];
        assign evt_mask[w*WORD_W +: WORD_W] = em_w[w];
    end

    always_comb begin
        prdata = '0;
        for (int b = 0; b < CFG_BANKS; b++) begin
            if (sel.idx == 4'(b)) begin
                case (sel.kind)
                    K_RISE:  prdata = rise_w[b];
                    K_FALL:  prdata = fall_w[b];
                    K_PEND:  prdata = pend_w[b];
                    default: ;
                endcase
            end
        end
        for (int w = 0; w < MASK_WORDS; w++) begin
            if (sel.idx == 4'(w)) begin
                case (sel.kind)
                    K_IMASK: prdata = im_w[w];
                    K_EMASK: prdata = em_w[w];
                    default: ;
                endcase
            end
        end
    end

    // R2: a refused write leaves configuration untouched and fires no trigger
    p_refused_write_r2: assert property (@(posedge pclk) disable iff (!presetn)
        (pslverr && pwrite) |=> ($stable(rise_en) && $stable(fall_en) && $stable(int_mask)
                                 && $stable(evt_mask) && sw_trig == '0));

    // R2: an error is only reported inside an access phase
    p_err_in_access_r2: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> (psel && penable));

endmodule

// File: tb/wkc_regbank_bench.sv
`timescale 1ns/1ps
module wkc_regbank_bench;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [63:0] pend_set = '0;
    logic [63:0] rise_en, fall_en, sw_trig, pending;
    logic [95:0] int_mask, evt_mask;

    always #4 pclk = ~pclk;

    wkc_regbank u_wkc_regbank (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .pend_set(pend_set), .rise_en(rise_en), .fall_en(fall_en),
        .sw_trig(sw_trig), .pending(pending), .int_mask(int_mask), .evt_mask(evt_mask)
    );

    // implemented bits and reset words, per R1 and R7
    localparam logic [31:0] CI [2] = '{32'h003F_FFFF, 32'h004A_4004};
    localparam logic [31:0] MI [3] = '{32'hFFFF_FFFF, 32'h0FFF_FFFF, 32'h0000_2000};
    localparam logic [31:0] MR [3] = '{32'hFFC0_0000, 32'h0FB5_BFFB, 32'h0000_2000};

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 0;

    logic [31:0] m_rise [2], m_fall [2], m_trig [2], m_pend [2];
    logic [31:0] m_im [3], m_em [3];
    logic [31:0] clr;
    bit          ok;

    // behavioural reference, one step per clock
    always @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            for (int b = 0; b < 2; b++) begin
                m_rise[b] = 0; m_fall[b] = 0; m_trig[b] = 0; m_pend[b] = 0;
            end
            for (int w = 0; w < 3; w++) begin
                m_im[w] = MR[w]; m_em[w] = 0;
            end
        end else begin
            ok = psel && penable && pwrite && pstrb == 4'hF && paddr[1:0] == 2'b00;
            for (int b = 0; b < 2; b++) begin
                clr = 0;
                m_trig[b] = 0;
                if (ok && paddr == 8'(32*b)) begin
                    clr = (m_rise[b] ^ pwdata) & CI[b]; m_rise[b] = pwdata & CI[b];
                end
                if (ok && paddr == 8'(32*b+4)) begin
                    clr = (m_fall[b] ^ pwdata) & CI[b]; m_fall[b] = pwdata & CI[b];
                end
                if (ok && paddr == 8'(32*b+8)) m_trig[b] = pwdata & CI[b];
                if (ok && paddr == 8'(136+16*b)) clr = pwdata & CI[b];
                m_pend[b] = ((m_pend[b] & ~clr) | pend_set[32*b +: 32]) & CI[b];
            end
            for (int w = 0; w < 3; w++) begin
                if (ok && paddr == 8'(128+16*w)) m_im[w] = pwdata & MI[w];
                if (ok && paddr == 8'(132+16*w)) m_em[w] = pwdata & MI[w];
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [7:0] a);
        logic [31:0] r = 0;
        for (int b = 0; b < 2; b++) begin
            if (a == 8'(32*b))    r = m_rise[b];
            if (a == 8'(32*b+4))  r = m_fall[b];
            if (a == 8'(136+16*b)) r = m_pend[b];
        end
        for (int w = 0; w < 3; w++) begin
            if (a == 8'(128+16*w)) r = m_im[w];
            if (a == 8'(132+16*w)) r = m_em[w];
        end
        return r;
    endfunction

    task automatic cmp64(string what, logic [63:0] act, logic [63:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge pclk) begin
        #1;
        if (cmp_en) begin
            n_cmp++;
            cmp64("R6 R7 rise_en", rise_en, {m_rise[1], m_rise[0]});
            cmp64("R6 R7 fall_en", fall_en, {m_fall[1], m_fall[0]});
            cmp64("R3 sw_trig", sw_trig, {m_trig[1], m_trig[0]});
            cmp64("R4 R5 R6 R8 pending", pending, {m_pend[1], m_pend[0]});
            cmp64("R9 int_mask lo", int_mask[63:0], {m_im[1], m_im[0]});
            cmp64("R9 int_mask hi", {32'h0, int_mask[95:64]}, {32'h0, m_im[2]});
            cmp64("R9 evt_mask lo", evt_mask[63:0], {m_em[1], m_em[0]});
            cmp64("R9 evt_mask hi", {32'h0, evt_mask[95:64]}, {32'h0, m_em[2]});
            cmp64("R2 pready", {63'h0, pready}, 64'h1);
            if (psel) cmp64("R10 prdata", {32'h0, prdata}, {32'h0, exp_read(paddr)});
            if (psel && penable)
                cmp64("R2 pslverr", {63'h0, pslverr},
                      {63'h0, (paddr[1:0] != 2'b00) || (pwrite && pstrb != 4'hF)});
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apb_write(logic [7:0] a, logic [31:0] d, logic [3:0] s,
                             logic [63:0] setv, output logic err);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pstrb = s;
        @(negedge pclk);
        penable = 1; pend_set = setv;
        #1 err = pslverr;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0; pend_set = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        logic e;
        apb_write(a, d, 4'hF, 64'h0, e);
    endtask

    task automatic apb_read(logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a; pstrb = 4'h0;
        @(negedge pclk);
        penable = 1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic pulse_set(logic [63:0] v);
        @(negedge pclk);
        pend_set = v;
        @(negedge pclk);
        pend_set = '0;
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        err;
        repeat (4) @(negedge pclk);
        presetn = 1;
        cmp_en  = 1;

        // R1 reset values
        apb_read(8'h80, rd); chk("R1 imask0", rd, 32'hFFC0_0000);
        apb_read(8'h90, rd); chk("R1 imask1", rd, 32'h0FB5_BFFB);
        apb_read(8'hA0, rd); chk("R1 imask2", rd, 32'h0000_2000);
        apb_read(8'h84, rd); chk("R1 emask0", rd, 32'h0);
        apb_read(8'h00, rd); chk("R1 rise0", rd, 32'h0);

        // R7 reserved bits
        wr(8'h00, 32'hFFFF_FFFF); apb_read(8'h00, rd); chk("R7 rise0 impl", rd, 32'h003F_FFFF);
        wr(8'h24, 32'hFFFF_FFFF); apb_read(8'h24, rd); chk("R7 fall1 impl", rd, 32'h004A_4004);
        wr(8'hA4, 32'hFFFF_FFFF); apb_read(8'hA4, rd); chk("R7 emask2 impl", rd, 32'h0000_2000);

        // R9 unmapped offsets
        wr(8'h40, 32'hFFFF_FFFF); apb_read(8'h40, rd); chk("R9 unmapped", rd, 32'h0);
        apb_read(8'h94, rd); chk("R9 emask1 untouched", rd, 32'h0);

        // R3 software trigger
        wr(8'h08, 32'h0000_0008);
        chk("R3 pulse high", sw_trig[31:0], 32'h8);
        @(posedge pclk); #1 chk("R3 pulse gone", sw_trig[31:0], 32'h0);
        wr(8'h28, 32'hFFFF_FFFF);
        chk("R3 bank1 pulse", sw_trig[63:32], 32'h004A_4004);
        apb_read(8'h08, rd); chk("R3 reads zero", rd, 32'h0);

        // R5 set strobes, reserved strobe bit ignored
        pulse_set(64'h0000_0000_0200_0020);
        apb_read(8'h88, rd); chk("R5 pend set", rd, 32'h20);

        // R4 write-one-to-clear
        wr(8'h88, 32'h0); apb_read(8'h88, rd); chk("R4 w0 keeps", rd, 32'h20);
        wr(8'h88, 32'h20); apb_read(8'h88, rd); chk("R4 w1 clears", rd, 32'h0);

        // R6 sensitivity change
        pulse_set(64'h20);
        wr(8'h00, 32'h003F_FFFF); apb_read(8'h88, rd); chk("R6 same value keeps", rd, 32'h20);
        wr(8'h00, 32'h003F_FFDF); apb_read(8'h88, rd); chk("R6 rise change clears", rd, 32'h0);
        pulse_set(64'h0000_0004_0000_0000);
        wr(8'h24, 32'h004A_4000); apb_read(8'h98, rd); chk("R6 fall change clears", rd, 32'h0);

        // R8 collisions
        pulse_set(64'h40);
        apb_write(8'h88, 32'h40, 4'hF, 64'h40, err);
        apb_read(8'h88, rd); chk("R8 set beats w1c", rd, 32'h40);
        apb_write(8'h00, 32'h003F_FF9F, 4'hF, 64'h40, err);
        apb_read(8'h88, rd); chk("R8 set beats sens change", rd, 32'h40);

        // R2 refused accesses
        apb_write(8'h84, 32'hFFFF, 4'h3, 64'h0, err);
        chk("R2 bad strobe err", {31'h0, err}, 32'h1);
        apb_read(8'h84, rd); chk("R2 bad strobe no write", rd, 32'h0);
        apb_write(8'h86, 32'hFFFF, 4'hF, 64'h0, err);
        chk("R2 misaligned err", {31'h0, err}, 32'h1);
        apb_write(8'h84, 32'h5, 4'hF, 64'h0, err);
        chk("R2 good write no err", {31'h0, err}, 32'h0);

        // random traffic with colliding strobes, judged by the model
        for (int i = 0; i < 600; i++) begin
            logic [7:0]  a;
            logic [3:0]  s;
            logic [63:0] sv;
            case ($urandom % 12)
                0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h08;  3: a = 8'h20;
                4: a = 8'h24;  5: a = 8'h28;  6: a = 8'h88;  7: a = 8'h98;
                8: a = 8'(8'h80 + 16 * ($urandom % 3));
                9: a = 8'(8'h84 + 16 * ($urandom % 3));
                10: a = 8'($urandom);
                default: a = 8'h88;
            endcase
            s  = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
            sv = ($urandom % 3 == 0) ? {$urandom, $urandom} : 64'h0;
            if ($urandom % 3 == 0) apb_read(a, rd);
            else apb_write(a, $urandom, s, sv, err);
        end

        repeat (2) @(negedge pclk);
        cmp_en = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule